// File: doc/BRIEF.md
# CAN FD Transmitter Delay Compensation Unit

During the fast data phase of a CAN FD frame the bit time can be shorter than the round trip from the controller's TX output, through the transceiver, and back to its RX input. A transmitter that checks its own bits at the normal sample point would then compare RX against the wrong bit. This unit moves that comparison to a secondary sample point (SSP). The SSP lies a loop delay plus a programmable offset after the start of each transmitted bit. Every position is counted in raw clock periods rather than time quanta.

The loop delay comes from one of two sources. In automatic mode the unit measures it again after every data-phase start strobe: it counts clock periods from the first falling TX edge to the same edge on the synchronised RX input. In manual mode a fixed programmed value is used. An optional filter window, which applies in automatic mode only, falls back to the normal sample point when the computed SSP is too early. The offset can also be given relative to the normal sample point.

The unit queues every transmitted bit together with its own sample time, so several bits can be in flight in the loop at once. It raises a bit-error pulse whenever RX at the SSP differs from the queued bit.

Top module: `tdc_ssp_unit`

## Requirements
- R1: When `bit_start` is high in cycle t, RX is sampled in cycle t+P and `ssp_strobe` is high in cycle t+P+1. While compensation is active, P is the delay plus the offset.
- R2: When only `mode_manual` is set, the delay is `cfg_delay`, saturated to 127.
- R3: When only `mode_auto` is set, the delay is the latest measurement and `cfg_delay` has no effect. A measurement counts the clock periods from the first TX 1-to-0 transition after `data_start` to the 1-to-0 transition of RX after its two-flop synchroniser. The result appears on `meas_delay` one cycle after the RX transition is seen.
- R4: When both mode bits are equal (both set or both clear), compensation is off. P is then the normal sample point (1+`seg_prop`+`seg_ph1`)×`presc`, clamped to 255, and the delay, offset and filter inputs have no effect.
- R5: In automatic mode, when the filter value is larger than the offset and delay+offset is below it, P is the normal sample point. In manual mode the filter has no effect.
- R6: When `rel_ofs` is set, `cfg_offset` is read as a signed two's-complement value added to the normal sample point. The sum is clamped to 0..127 and used as the offset.
- R7: The absolute offset is saturated to 127. A measurement that reaches 127 stays at 127. The delay+offset sum reaches at most 254.
- R8: At least four transmitted bits can wait in the delay line at once. Each one is sampled at its own position, in the order the bits were sent.
- R9: `bit_err` is high in exactly the cycles in which `ssp_strobe` is high and the RX sample differs from the queued TX bit.
- R10: `data_start` empties the delay line. No strobe follows for a bit queued before it, and `ssp_strobe` is low in the cycle after it.
- R11: A position that works out to 0 is raised to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one minimum time quantum |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_start | input | 1 | Start-of-data-phase strobe: flushes the queue and arms a measurement |
| bit_start | input | 1 | Marks the first clock of a transmitted bit |
| tx_bit | input | 1 | TX bit stream, 1 is recessive |
| rx_pin | input | 1 | Raw RX input, asynchronous |
| mode_auto | input | 1 | Measured delay mode |
| mode_manual | input | 1 | Programmed delay mode |
| rel_ofs | input | 1 | Offset is signed and relative to the normal sample point |
| cfg_delay | input | 8 | Programmed delay, in clock periods |
| cfg_offset | input | 8 | Offset, in clock periods |
| cfg_filter | input | 8 | Minimum SSP position for automatic mode |
| seg_prop | input | 6 | Propagation segment, in quanta |
| seg_ph1 | input | 6 | Phase segment 1, in quanta |
| presc | input | 5 | Prescaler, clock periods per quantum |
| ssp_strobe | output | 1 | One-cycle strobe, registered, one cycle after the SSP sample |
| meas_delay | output | 7 | Latest measured loop delay |
| bit_err | output | 1 | Mismatch at the SSP, coincident with the strobe |

## Verification
All results have fixed latencies. A bit started in cycle t shows its strobe, and any error, in cycle t+P+1. A measurement started by a TX fall in cycle t0 over a modelled loop of L cycles yields L+2 on `meas_delay` from cycle t0+L+3. The bench stamps every strobe with a free-running cycle counter and compares the stamp against the expected t+P+1. Error counts are compared only once the strobes of all bits have fallen due. The RX loop is modelled as a shift register of TX, with an optional inversion to force mismatches.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

   localparam int TDC_DLY_W = 7;
   localparam int TDC_CFG_W = 8;
   localparam int TDC_SEG_W = 6;
   localparam int TDC_BRP_W = 5;

   typedef enum logic [1:0] {
      TDC_OFF    = 2'd0,
      TDC_AUTO   = 2'd1,
      TDC_MANUAL = 2'd2
   } tdc_mode_e;

   // Equal mode bits (both set or both clear) mean no compensation.
   function automatic tdc_mode_e tdc_mode_of(input logic auto_b, input logic man_b);
      if (auto_b && !man_b)      return TDC_AUTO;
      else if (man_b && !auto_b) return TDC_MANUAL;
      else                       return TDC_OFF;
   endfunction

endpackage

// File: rtl/tdc_delay_meas.sv
module tdc_delay_meas #(
   parameter int DLY_W       = tdc_pkg::TDC_DLY_W,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_start,
   input  logic             tx_bit,
   input  logic             rx_pin,
   output logic             rx_sync,
   output logic [DLY_W-1:0] meas_delay,
   output logic             meas_armed
);

   localparam logic [DLY_W-1:0] CNT_MAX = '1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tdc_delay_meas: SYNC_STAGES must be at least 2");
   end

   // RX synchroniser, one flop per stage, recessive at reset.
   logic [SYNC_STAGES-1:0] sync_q;
   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      sync_q[s] <= 1'b1;
         else if (s == 0) sync_q[s] <= rx_pin;
         else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
   end
   assign rx_sync = sync_q[SYNC_STAGES-1];

   logic             tx_prev, rx_prev, counting;
   logic [DLY_W-1:0] cnt;
   logic             tx_fall, rx_fall;

   assign tx_fall = tx_prev & ~tx_bit;
   assign rx_fall = rx_prev & ~rx_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_prev    <= 1'b1;
         rx_prev    <= 1'b1;
         meas_armed <= 1'b0;
         counting   <= 1'b0;
         cnt        <= '0;
         meas_delay <= '0;
      end else begin
         tx_prev <= tx_bit;
         rx_prev <= rx_sync;
         if (data_start) begin
            meas_armed <= 1'b1;
            counting   <= 1'b0;
            cnt        <= '0;
         end else if (meas_armed && !counting && tx_fall) begin
            if (rx_fall) begin
               meas_delay <= '0;
               meas_armed <= 1'b0;
            end else begin
               counting <= 1'b1;
               cnt      <= DLY_W'(1);
            end
         end else if (counting) begin
            if (rx_fall) begin
               meas_delay <= cnt;
               counting   <= 1'b0;
               meas_armed <= 1'b0;
            end else if (cnt != CNT_MAX) begin
               cnt <= cnt + DLY_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/tdc_pos_calc.sv
module tdc_pos_calc
   import tdc_pkg::*;
#(
   parameter int CFG_W      = tdc_pkg::TDC_CFG_W,
   parameter int DLY_W      = tdc_pkg::TDC_DLY_W,
   parameter int SEG_W      = tdc_pkg::TDC_SEG_W,
   parameter int BRP_W      = tdc_pkg::TDC_BRP_W,
   parameter bit REL_OFS_EN = 1'b1
) (
   input  tdc_mode_e        mode,
   input  logic             rel_ofs,
   input  logic [CFG_W-1:0] cfg_delay,
   input  logic [CFG_W-1:0] cfg_offset,
   input  logic [CFG_W-1:0] cfg_filter,
   input  logic [SEG_W-1:0] seg_prop,
   input  logic [SEG_W-1:0] seg_ph1,
   input  logic [BRP_W-1:0] presc,
   input  logic [DLY_W-1:0] meas_delay,
   output logic [DLY_W:0]   ssp_pos
);

   localparam int SP_W = SEG_W + 1 + BRP_W;
   localparam int RS_W = SP_W + 2;
   localparam logic [DLY_W-1:0] DLY_MAX = '1;
   localparam logic [DLY_W:0]   POS_MAX = '1;

   if (CFG_W < DLY_W + 1) begin : g_bad_cfg
      $error("tdc_pos_calc: CFG_W must exceed DLY_W");
   end
   if (SP_W < DLY_W + 1 || RS_W <= CFG_W) begin : g_bad_sp
      $error("tdc_pos_calc: sample point width too small");
   end

   // Normal sample point in clock periods.
   logic [SP_W-1:0] sp_full;
   logic [DLY_W:0]  sp_pos;
   assign sp_full = (SP_W'(seg_prop) + SP_W'(seg_ph1) + SP_W'(1)) * SP_W'(presc);
   assign sp_pos  = (sp_full > SP_W'(POS_MAX)) ? POS_MAX : sp_full[DLY_W:0];

   logic [DLY_W-1:0] dly_cfg, ofs_abs, ofs, dly;
   assign dly_cfg = (cfg_delay  > CFG_W'(DLY_MAX)) ? DLY_MAX : cfg_delay[DLY_W-1:0];
   assign ofs_abs = (cfg_offset > CFG_W'(DLY_MAX)) ? DLY_MAX : cfg_offset[DLY_W-1:0];

   if (REL_OFS_EN) begin : g_rel
      logic signed [RS_W-1:0] rel_sum;
      logic [DLY_W-1:0]       ofs_rel;
      assign rel_sum = RS_W'($signed(cfg_offset)) + $signed({2'b00, sp_full});
      always_comb begin
         if (rel_sum[RS_W-1])                              ofs_rel = '0;
         else if (rel_sum[RS_W-2:0] > (RS_W-1)'(DLY_MAX))  ofs_rel = DLY_MAX;
         else                                              ofs_rel = rel_sum[DLY_W-1:0];
      end
      assign ofs = rel_ofs ? ofs_rel : ofs_abs;
   end else begin : g_abs
      assign ofs = ofs_abs;
   end

   assign dly = (mode == TDC_AUTO) ? meas_delay : dly_cfg;

   logic [DLY_W:0] sum, filt, raw;
   logic           filt_on, comp_on;
   assign sum     = {1'b0, dly} + {1'b0, ofs};
   assign filt    = (cfg_filter > CFG_W'(POS_MAX)) ? POS_MAX : cfg_filter[DLY_W:0];
   assign filt_on = (mode == TDC_AUTO) && (filt > {1'b0, ofs});
   assign comp_on = (mode != TDC_OFF) && !(filt_on && (sum < filt));
   assign raw     = comp_on ? sum : sp_pos;
   assign ssp_pos = (raw == '0) ? (DLY_W+1)'(1) : raw;

endmodule

// File: rtl/tdc_bit_queue.sv
module tdc_bit_queue #(
   parameter int DEPTH = 4,
   parameter int POS_W = tdc_pkg::TDC_DLY_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             push_bit,
   input  logic [POS_W-1:0] pos,
   input  logic             rx_sync,
   output logic             ssp_strobe,
   output logic             bit_err,
   output logic [DEPTH-1:0] q_vld
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   if (DEPTH < 4) begin : g_bad_depth
      $error("tdc_bit_queue: DEPTH must be at least 4");
   end

   logic [PTR_W-1:0] wptr;
   logic [DEPTH-1:0] hit, mis;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic             v, b;
      logic [POS_W-1:0] c;
      logic             take;
      assign take     = push && (wptr == PTR_W'(i));
      assign hit[i]   = v && (c == POS_W'(1)) && !flush;
      assign mis[i]   = hit[i] && (b != rx_sync);
      assign q_vld[i] = v;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v <= 1'b0;
            b <= 1'b1;
            c <= '0;
         end else if (flush) begin
            v <= 1'b0;
         end else if (take) begin
            v <= 1'b1;
            b <= push_bit;
            c <= pos;
         end else if (hit[i]) begin
            v <= 1'b0;
         end else if (v) begin
            c <= c - POS_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr       <= '0;
         ssp_strobe <= 1'b0;
         bit_err    <= 1'b0;
      end else begin
         ssp_strobe <= |hit;
         bit_err    <= |mis;
         if (flush)     wptr <= '0;
         else if (push) wptr <= (wptr == LAST) ? '0 : wptr + PTR_W'(1);
      end
   end

endmodule

// File: rtl/tdc_ssp_unit.sv
module tdc_ssp_unit
   import tdc_pkg::*;
#(
   parameter int CFG_W       = tdc_pkg::TDC_CFG_W,
   parameter int DLY_W       = tdc_pkg::TDC_DLY_W,
   parameter int SEG_W       = tdc_pkg::TDC_SEG_W,
   parameter int BRP_W       = tdc_pkg::TDC_BRP_W,
   parameter int DEPTH       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit REL_OFS_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_start,
   input  logic             bit_start,
   input  logic             tx_bit,
   input  logic             rx_pin,
   input  logic             mode_auto,
   input  logic             mode_manual,
   input  logic             rel_ofs,
   input  logic [CFG_W-1:0] cfg_delay,
   input  logic [CFG_W-1:0] cfg_offset,
   input  logic [CFG_W-1:0] cfg_filter,
   input  logic [SEG_W-1:0] seg_prop,
   input  logic [SEG_W-1:0] seg_ph1,
   input  logic [BRP_W-1:0] presc,
   output logic             ssp_strobe,
   output logic [DLY_W-1:0] meas_delay,
   output logic             bit_err
);

   localparam int POS_W = DLY_W + 1;

   tdc_mode_e        mode;
   logic             rx_sync, meas_armed;
   logic [POS_W-1:0] ssp_pos;
   logic [DEPTH-1:0] q_vld;

   assign mode = tdc_mode_of(mode_auto, mode_manual);

   tdc_delay_meas #(.DLY_W(DLY_W), .SYNC_STAGES(SYNC_STAGES)) meas_i (
      .clk(clk), .rst_n(rst_n), .data_start(data_start), .tx_bit(tx_bit),
      .rx_pin(rx_pin), .rx_sync(rx_sync), .meas_delay(meas_delay),
      .meas_armed(meas_armed)
   );

   tdc_pos_calc #(.CFG_W(CFG_W), .DLY_W(DLY_W), .SEG_W(SEG_W), .BRP_W(BRP_W),
                  .REL_OFS_EN(REL_OFS_EN)) pos_i (
      .mode(mode), .rel_ofs(rel_ofs), .cfg_delay(cfg_delay),
      .cfg_offset(cfg_offset), .cfg_filter(cfg_filter), .seg_prop(seg_prop),
      .seg_ph1(seg_ph1), .presc(presc), .meas_delay(meas_delay),
      .ssp_pos(ssp_pos)
   );

   tdc_bit_queue #(.DEPTH(DEPTH), .POS_W(POS_W)) queue_i (
      .clk(clk), .rst_n(rst_n), .flush(data_start), .push(bit_start),
      .push_bit(tx_bit), .pos(ssp_pos), .rx_sync(rx_sync),
      .ssp_strobe(ssp_strobe), .bit_err(bit_err), .q_vld(q_vld)
   );

endmodule

// File: rtl/tdc_ssp_unit_chk.sv
module tdc_ssp_unit_chk #(
   parameter int DLY_W = tdc_pkg::TDC_DLY_W,
   parameter int DEPTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             data_start,
   input logic             ssp_strobe,
   input logic             bit_err,
   input logic [DLY_W-1:0] meas_delay,
   input logic             meas_armed,
   input logic [DEPTH-1:0] q_vld
);

   // R9: an error is only reported at a secondary sample point
   a_r9_err_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      bit_err |-> ssp_strobe);

   // R10: the flush strobe leaves an empty line and no strobe behind
   a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      data_start |=> (q_vld == '0) && !ssp_strobe);

   // R8: every strobe comes from a bit that was waiting in the line
   a_r8_strobe_from_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ssp_strobe |-> $past(q_vld != '0));

   // R3: the measured delay changes only while a measurement is armed
   a_r3_meas_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_armed |=> $stable(meas_delay));

endmodule

bind tdc_ssp_unit tdc_ssp_unit_chk #(.DLY_W(DLY_W), .DEPTH(DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .data_start(data_start), .ssp_strobe(ssp_strobe),
   .bit_err(bit_err), .meas_delay(meas_delay), .meas_armed(meas_armed),
   .q_vld(q_vld)
);

// File: tb/tdc_ssp_unit_tb_top.sv
`timescale 1ns/1ps
module tdc_ssp_unit_tb_top;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0, data_start = 1'b0, bit_start = 1'b0, tx_bit = 1'b1;
   logic       rx_pin, mode_auto = 1'b0, mode_manual = 1'b0, rel_ofs = 1'b0;
   logic [7:0] cfg_delay = '0, cfg_offset = '0, cfg_filter = '0;
   logic [5:0] seg_prop = '0, seg_ph1 = '0;
   logic [4:0] presc = '0;
   logic       ssp_strobe, bit_err;
   logic [6:0] meas_delay;

   // Loop model: RX is TX delayed by loop_l cycles, optionally inverted.
   logic [255:0] sr = '1;
   int           loop_l = 0;
   logic         inj = 1'b0;
   always @(posedge clk) sr <= {sr[254:0], tx_bit};
   assign rx_pin = ((loop_l == 0) ? tx_bit : sr[loop_l-1]) ^ inj;

   tdc_ssp_unit dut_i (
      .clk(clk), .rst_n(rst_n), .data_start(data_start), .bit_start(bit_start),
      .tx_bit(tx_bit), .rx_pin(rx_pin), .mode_auto(mode_auto),
      .mode_manual(mode_manual), .rel_ofs(rel_ofs), .cfg_delay(cfg_delay),
      .cfg_offset(cfg_offset), .cfg_filter(cfg_filter), .seg_prop(seg_prop),
      .seg_ph1(seg_ph1), .presc(presc), .ssp_strobe(ssp_strobe),
      .meas_delay(meas_delay), .bit_err(bit_err)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_strobe = 0, n_err = 0, n_orphan = 0, last_cyc = 0;
   always @(negedge clk) if (rst_n) begin
      if (ssp_strobe) begin n_strobe++; last_cyc = cyc; end
      if (bit_err) begin n_err++; if (!ssp_strobe) n_orphan++; end
   end

   int  n_tests = 0, n_fail = 0;
   bit  done = 1'b0;

   task automatic check_eq(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_bit(input logic b, output int n);
      @(negedge clk); bit_start = 1'b1; tx_bit = b; n = cyc;
      @(negedge clk); bit_start = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); data_start = 1'b1;
      @(negedge clk); data_start = 1'b0;
   endtask

   task automatic set_mode(input logic a, input logic m);
      @(negedge clk); mode_auto = a; mode_manual = m;
   endtask

   // R1: strobe stamp equals push cycle + 1 + expected position
   task automatic expect_pos(input string tag, input int exp);
      int n, s0;
      s0 = n_strobe;
      push_bit(1'b1, n);
      for (int k = 0; k < 300 && n_strobe == s0; k++) @(posedge clk);
      check_eq(tag, last_cyc - (n + 1), exp);
      idle(3);
   endtask

   task automatic measure(input int l, input int hold, input int exp, input string tag);
      loop_l = l; idle(l + 4);
      pulse_start();
      @(negedge clk); tx_bit = 1'b0;
      idle(hold);
      check_eq(tag, int'(meas_delay), exp);
      tx_bit = 1'b1;
      idle(l + 6);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; idle(5); rst_n = 1'b1; idle(1);
      check_eq("reset strobe", int'(ssp_strobe), 0);
      check_eq("reset bit_err", int'(bit_err), 0);
      check_eq("reset meas_delay", int'(meas_delay), 0);
   endtask

   task automatic t_manual();
      set_mode(1'b0, 1'b1);
      cfg_delay = 8'd10; cfg_offset = 8'd5;
      expect_pos("R1 R2 manual 10+5", 15);
      cfg_delay = 8'd200; cfg_offset = 8'd3;
      expect_pos("R2 manual delay saturation", 130);
      cfg_delay = 8'd200; cfg_offset = 8'd250;
      expect_pos("R7 offset and delay saturation", 254);
      cfg_delay = 8'd0; cfg_offset = 8'd0;
      expect_pos("R11 zero position raised", 1);
   endtask

   task automatic t_relative();
      set_mode(1'b0, 1'b1);
      seg_prop = 6'd2; seg_ph1 = 6'd3; presc = 5'd2;   // normal SP = 12
      rel_ofs = 1'b1; cfg_delay = 8'd10;
      cfg_offset = 8'hFC;  expect_pos("R6 relative -4", 18);
      cfg_offset = 8'hEC;  expect_pos("R6 relative clamp low", 10);
      cfg_offset = 8'd120; expect_pos("R6 relative clamp high", 137);
      rel_ofs = 1'b0;
   endtask

   task automatic t_disabled();
      cfg_delay = 8'd9; cfg_offset = 8'd9; cfg_filter = 8'd0;
      set_mode(1'b0, 1'b0); expect_pos("R4 neither mode bit", 12);
      set_mode(1'b1, 1'b1); expect_pos("R4 both mode bits", 12);
      seg_prop = 6'd63; seg_ph1 = 6'd63; presc = 5'd31;
      expect_pos("R4 normal point clamp", 255);
   endtask

   task automatic t_auto_filter();
      set_mode(1'b1, 1'b0);
      cfg_delay = 8'd50; cfg_offset = 8'd4; cfg_filter = 8'd0;
      measure(5, 15, 7, "R3 measured loop 5+2");
      expect_pos("R3 auto ignores programmed delay", 11);
      seg_prop = 6'd4; seg_ph1 = 6'd5; presc = 5'd3;   // normal SP = 30
      cfg_filter = 8'd20; expect_pos("R5 filter falls back", 30);
      cfg_filter = 8'd10; expect_pos("R5 filter passes", 11);
      set_mode(1'b0, 1'b1); cfg_delay = 8'd2; cfg_filter = 8'd20;
      expect_pos("R5 filter inactive in manual", 6);
      cfg_filter = 8'd0;
   endtask

   task automatic t_queue();
      int n0, n, s0;
      set_mode(1'b0, 1'b1); cfg_delay = 8'd15; cfg_offset = 8'd5;
      s0 = n_strobe;
      push_bit(1'b1, n0); idle(1);
      for (int i = 0; i < 3; i++) begin push_bit(1'b1, n); idle(1); end
      check_eq("R8 no early strobe", n_strobe - s0, 0);
      for (int k = 0; k < 100 && n_strobe == s0; k++) @(posedge clk);
      check_eq("R8 first in-flight bit", last_cyc - (n0 + 1), 20);
      for (int k = 0; k < 100 && n_strobe < s0 + 4; k++) @(posedge clk);
      check_eq("R8 fourth in-flight bit", last_cyc - (n0 + 1), 29);
      idle(10);
      check_eq("R8 strobe count", n_strobe - s0, 4);
   endtask

   task automatic t_errors();
      int n, s0, e0;
      logic pat [8] = '{1, 0, 1, 1, 0, 0, 1, 0};
      set_mode(1'b1, 1'b0); cfg_offset = 8'd2; cfg_filter = 8'd0;
      measure(3, 10, 5, "R3 measured loop 3+2");
      s0 = n_strobe; e0 = n_err;
      for (int i = 0; i < 8; i++) begin push_bit(pat[i], n); idle(8); end
      idle(12); tx_bit = 1'b1; idle(8);
      check_eq("R9 matching bits strobes", n_strobe - s0, 8);
      check_eq("R9 matching bits no error", n_err - e0, 0);
      @(negedge clk); inj = 1'b1;
      s0 = n_strobe; e0 = n_err;
      for (int i = 0; i < 8; i++) begin push_bit(pat[i], n); idle(8); end
      idle(12);
      check_eq("R9 one error pulse per bad bit", n_err - e0, 8);
      check_eq("R9 errors only with strobe", n_orphan, 0);
      @(negedge clk); inj = 1'b0; tx_bit = 1'b1; idle(10);
   endtask

   task automatic t_sat_meas();
      set_mode(1'b1, 1'b0);
      measure(200, 215, 127, "R7 measurement saturates");
      loop_l = 0; idle(10);
   endtask

   task automatic t_flush();
      int n, s0;
      set_mode(1'b0, 1'b1); cfg_delay = 8'd20; cfg_offset = 8'd10;
      s0 = n_strobe;
      push_bit(1'b1, n); idle(5);
      pulse_start(); idle(40);
      check_eq("R10 flushed bit gives no strobe", n_strobe - s0, 0);
   endtask

   initial begin
      t_reset();
      t_manual();
      t_relative();
      t_disabled();
      t_auto_filter();
      t_queue();
      t_errors();
      t_sat_meas();
      t_flush();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule